// File: doc/BRIEF.md
# Quarter-Rate IQ Down-Converter with CIC Decimation

This block turns a one-bit oversampled stream, as produced by a bandpass delta-sigma modulator, into complex baseband words. It takes one bit per sample clock. The bit is mixed to zero frequency by in-phase and quadrature oscillators that run at one quarter of that clock. Each branch is then low-pass filtered and decimated by a power of two, and the block delivers signed I and Q words with a one-cycle strobe at the reduced rate.

With the oscillator at exactly a quarter of the sample rate and a one-bit input, the mixer needs no multiplier. Each branch passes, negates or zeroes a ±1 level in a fixed four-step pattern. A second-order cascaded integrator-comb (CIC) filter per branch does the decimation. The decimation exponent is taken from an input while reset is held, so one build can serve ratios from 4 up to 256.

Top module: `qddc_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is cleared and `i_out` and `q_out` are cleared to zero. This also applies to a reset issued in the middle of a run.
- R2: After reset, `out_valid` is high for exactly one clock in every 2^n clocks, where n is the effective decimation exponent.
- R3: The first two decimated results are suppressed. Edge 0 is the first rising edge with `rst` low. `out_valid` first rises after edge 3·2^n−1 and stays low before that.
- R4: An input bit of 1 counts as +1 and a bit of 0 counts as −1. A two-bit phase counter starts at 0 on edge 0 and advances by one each clock. By phase 0,1,2,3, the in-phase branch takes +x, 0, −x, 0 and the quadrature branch takes 0, +x, 0, −x.
- R5: Let R = 2^n, and let xI[k] and xQ[k] be the mixed samples at edge k. The word presented after edge mR−1 is the sum, over d from 1 to 2R−1, of tri(d)·x[mR−2−d]. Here tri(d) = d for d ≤ R, tri(d) = 2R−d otherwise, and samples before edge 0 count as zero.
- R6: A repeating input of 1,1,0,0, starting at edge 0, gives a steady I = Q = 2^(2n−1) on every valid strobe.
- R7: `i_out` and `q_out` are 2·8+2 = 18 bits wide, two's complement, and never exceed 2^(2n−1) in magnitude. They change only in cycles where `out_valid` is high, and hold their value between strobes.
- R8: `dec_exp` is sampled only while `rst` is high. Changing it after reset has no effect on strobe spacing or on output values until the next reset.
- R9: The effective exponent is `dec_exp` clamped to the range 2..8. Values below 2 act as 2 and values above 8 act as 8.
- R10: With n = 8 the block decimates by 256. The strobe spacing is 256 clocks, and the words follow R5 without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one input bit per rising edge |
| rst | input | 1 | Synchronous active-high reset; also captures `dec_exp` |
| bit_in | input | 1 | Single-bit modulator output (1 = +1, 0 = −1) |
| dec_exp | input | 4 | Decimation exponent n, sampled during reset, clamped to 2..8 |
| i_out | output | 18 | Signed in-phase baseband word |
| q_out | output | 18 | Signed quadrature baseband word |
| out_valid | output | 1 | One-cycle strobe marking a new I/Q word |

## Verification
The all-ones stream makes the mixer output a pure quarter-rate sequence on each branch. A mixer with a swapped or mis-phased oscillator therefore shows up as a wrong sign or a wrong branch. The repeating 1,1,0,0 stream puts a tone exactly on the oscillator frequency, which must give a constant, equal and non-zero I and Q of 2^(2n−1), and it is run at both the smallest and the largest ratio. The alternating 1,0 stream and a pseudo-random stream exercise the full triangular weighting of the filter, so an error in the integrator order, the comb delay or the tick alignment shows up as a mismatch against the reference sum. Out-of-range and mid-run exponent changes tell correct clamping and reset-only capture apart from a live exponent input.

// File: rtl/qddc_pkg.sv
package qddc_pkg;

    localparam int unsigned DEF_EXP_MIN = 2;
    localparam int unsigned DEF_EXP_MAX = 8;

    // Oscillator phase, advancing a quarter turn per sample
    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } lo_phase_e;

    // Ternary level -1, 0, +1
    typedef logic signed [1:0] tern_t;

    typedef struct packed {
        tern_t i_part;
        tern_t q_part;
    } mix_pair_t;

    function automatic tern_t bit_to_level(logic b);
        return b ? 2'sb01 : 2'sb11;
    endfunction

    // Multiplier-free quarter-rate mixing of a one-bit sample
    function automatic mix_pair_t quarter_mix(lo_phase_e ph, logic b);
        mix_pair_t r;
        tern_t     lvl;
        lvl = bit_to_level(b);
        r   = '0;
        case (ph)
            PH_0:    r.i_part = lvl;
            PH_90:   r.q_part = lvl;
            PH_180:  r.i_part = -lvl;
            default: r.q_part = -lvl;
        endcase
        return r;
    endfunction

    function automatic int unsigned clamp_exp(int unsigned e, int unsigned lo, int unsigned hi);
        if (e < lo) return lo;
        if (e > hi) return hi;
        return e;
    endfunction

endpackage

// File: rtl/qddc_lo_mixer.sv
module qddc_lo_mixer
    import qddc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_in,
    output mix_pair_t mix
);

    lo_phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_0;
        end else begin
            phase <= lo_phase_e'(phase + 2'd1);
        end
    end

    always_comb begin
        mix = quarter_mix(phase, bit_in);
    end

endmodule

// File: rtl/qddc_rate_ctrl.sv
module qddc_rate_ctrl
    import qddc_pkg::*;
#(
    parameter int unsigned EXP_MIN = DEF_EXP_MIN,
    parameter int unsigned EXP_MAX = DEF_EXP_MAX,
    parameter int unsigned EXP_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] dec_exp,
    output logic             tick,
    output logic             fire
);

    localparam int unsigned PRIME_TICKS = 2;

    logic [EXP_W-1:0]   n_cur;
    logic [EXP_MAX-1:0] sample_cnt;
    logic [EXP_MAX-1:0] mask;
    logic [1:0]         primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_cur      <= EXP_W'(clamp_exp(32'(dec_exp), EXP_MIN, EXP_MAX));
            sample_cnt <= '0;
            primed     <= '0;
        end else begin
            sample_cnt <= sample_cnt + 1'b1;
            if (tick && (primed != 2'(PRIME_TICKS))) begin
                primed <= primed + 2'd1;
            end
        end
    end

    // Low n bits of the free-running counter select the decimation phase
    always_comb begin
        for (int b = 0; b < int'(EXP_MAX); b++) begin
            mask[b] = (b < int'(n_cur));
        end
    end

    assign tick = ((sample_cnt & mask) == mask);
    assign fire = tick && (primed == 2'(PRIME_TICKS));

endmodule

// File: rtl/qddc_cic2.sv
module qddc_cic2
    import qddc_pkg::*;
#(
    parameter int unsigned ACC_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  tern_t                   x,
    input  logic                    tick,
    input  logic                    fire,
    output logic signed [ACC_W-1:0] y
);

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] integ1, integ2;
    logic signed [ACC_W-1:0] comb_d1, comb_d2;
    logic signed [ACC_W-1:0] diff1, diff2;

    assign x_ext = {{(ACC_W-2){x[1]}}, x};
    assign diff1 = integ2 - comb_d1;
    assign diff2 = diff1 - comb_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            integ1  <= '0;
            integ2  <= '0;
            comb_d1 <= '0;
            comb_d2 <= '0;
            y       <= '0;
        end else begin
            integ1 <= integ1 + x_ext;
            integ2 <= integ2 + integ1;
            if (tick) begin
                comb_d1 <= integ2;
                comb_d2 <= diff1;
            end
            if (fire) begin
                y <= diff2;
            end
        end
    end

endmodule

// File: rtl/qddc_top.sv
module qddc_top
    import qddc_pkg::*;
#(
    parameter  int unsigned EXP_MIN = DEF_EXP_MIN,
    parameter  int unsigned EXP_MAX = DEF_EXP_MAX,
    localparam int unsigned EXP_W   = $clog2(EXP_MAX + 1),
    localparam int unsigned OUT_W   = 2 * EXP_MAX + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    input  logic [EXP_W-1:0]        dec_exp,
    output logic signed [OUT_W-1:0] i_out,
    output logic signed [OUT_W-1:0] q_out,
    output logic                    out_valid
);

    localparam int unsigned N_BRANCH = 2;

    mix_pair_t               mix;
    logic                    tick;
    logic                    fire;
    tern_t                   branch_in  [N_BRANCH];
    logic signed [OUT_W-1:0] branch_out [N_BRANCH];

    qddc_lo_mixer u_mixer (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .mix    (mix)
    );

    qddc_rate_ctrl #(
        .EXP_MIN (EXP_MIN),
        .EXP_MAX (EXP_MAX),
        .EXP_W   (EXP_W)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .dec_exp (dec_exp),
        .tick    (tick),
        .fire    (fire)
    );

    assign branch_in[0] = mix.i_part;
    assign branch_in[1] = mix.q_part;

    for (genvar g = 0; g < int'(N_BRANCH); g++) begin : g_branch
        qddc_cic2 #(
            .ACC_W (OUT_W)
        ) u_cic (
            .clk  (clk),
            .rst  (rst),
            .x    (branch_in[g]),
            .tick (tick),
            .fire (fire),
            .y    (branch_out[g])
        );
    end

    assign i_out = branch_out[0];
    assign q_out = branch_out[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= fire;
        end
    end

endmodule

// File: rtl/qddc_checker.sv
module qddc_checker
    import qddc_pkg::*;
#(
    parameter int unsigned EXP_MIN = DEF_EXP_MIN,
    parameter int unsigned EXP_MAX = DEF_EXP_MAX,
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned OUT_W   = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic [EXP_W-1:0]        dec_exp,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] i_out,
    input logic signed [OUT_W-1:0] q_out
);

    localparam int unsigned EDGE_SAT = 1 << 20;

    int unsigned n_chk;
    int unsigned period;
    int          limit;
    int unsigned edge_cnt;
    int unsigned gap;
    logic        seen;
    int          i_mag, q_mag;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_chk    <= clamp_exp(32'(dec_exp), EXP_MIN, EXP_MAX);
            edge_cnt <= 0;
            gap      <= 0;
            seen     <= 1'b0;
        end else begin
            if (edge_cnt < EDGE_SAT) edge_cnt <= edge_cnt + 1;
            if (out_valid) begin
                gap  <= 1;
                seen <= 1'b1;
            end else begin
                gap <= gap + 1;
            end
        end
    end

    always_comb begin
        period = 1 << n_chk;
        limit  = 1 << (2 * n_chk - 1);
        i_mag  = (int'(i_out) < 0) ? -int'(i_out) : int'(i_out);
        q_mag  = (int'(q_out) < 0) ? -int'(q_out) : int'(q_out);
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && i_out == '0 && q_out == '0));

    // R2 and R8: spacing follows the exponent captured in reset
    p_strobe_period_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen) |-> (gap == period));

    p_no_early_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (edge_cnt >= 3 * period));

    p_first_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (edge_cnt == 3 * period) |-> out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(i_out) || !$stable(q_out)) |-> out_valid);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (i_mag <= limit) && (q_mag <= limit));

endmodule

bind qddc_top qddc_checker #(
    .EXP_MIN (EXP_MIN),
    .EXP_MAX (EXP_MAX),
    .EXP_W   (EXP_W),
    .OUT_W   (OUT_W)
) u_check (
    .clk       (clk),
    .rst       (rst),
    .dec_exp   (dec_exp),
    .out_valid (out_valid),
    .i_out     (i_out),
    .q_out     (q_out)
);

// File: tb/qddc_top_test.sv
module qddc_top_test;

    localparam int OW = 18;

    typedef struct packed {
        logic [3:0]  n;
        logic [3:0]  n_after;
        logic [15:0] pat;
        logic        use_lfsr;
        logic        tone;
        logic [1:0]  nout;
    } vec_t;

    // exponent, exponent after reset, pattern, lfsr, tone, outputs
    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd2,  4'd2,  16'h3333, 1'b0, 1'b1, 2'd3},
        '{4'd4,  4'd4,  16'hFFFF, 1'b0, 1'b0, 2'd3},
        '{4'd3,  4'd3,  16'h5555, 1'b0, 1'b0, 2'd3},
        '{4'd5,  4'd5,  16'h0000, 1'b1, 1'b0, 2'd3},
        '{4'd8,  4'd8,  16'h3333, 1'b0, 1'b1, 2'd2},
        '{4'd0,  4'd0,  16'h0000, 1'b1, 1'b0, 2'd3},
        '{4'd15, 4'd15, 16'h0000, 1'b0, 1'b0, 2'd1},
        '{4'd3,  4'd6,  16'h0000, 1'b1, 1'b0, 2'd3}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bit_in = 1'b0;
    logic [3:0]           dec_exp = 4'd2;
    logic signed [OW-1:0] i_out, q_out;
    logic                 out_valid;

    int checks = 0;
    int fails  = 0;
    int xi [0:2047];
    int xq [0:2047];

    always #4 clk = ~clk;

    qddc_top uut (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .dec_exp   (dec_exp),
        .i_out     (i_out),
        .q_out     (q_out),
        .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clampn(int n);
        if (n < 2) return 2;
        if (n > 8) return 8;
        return n;
    endfunction

    task automatic run_vec(input vec_t v);
        int          ne;
        int          rr;
        int          total;
        int          last_i;
        int          last_q;
        logic [15:0] lf;
        string       tag;
        ne     = clampn(int'(v.n));
        rr     = 1 << ne;
        total  = (3 + int'(v.nout)) * rr;
        last_i = 0;
        last_q = 0;
        lf     = 16'hACE1;
        if (v.n < 4'd2 || v.n > 4'd8)   tag = "R9";
        else if (v.n != v.n_after)      tag = "R8";
        else if (ne == 8)               tag = "R10";
        else                            tag = "R4/R5";

        rst     = 1'b1;
        dec_exp = v.n;
        repeat (3) @(negedge clk);
        // R1: cleared by reset, also after a previous run
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(i_out == '0 && q_out == '0, "R1 data", int'(i_out), 0);
        rst     = 1'b0;
        dec_exp = v.n_after;

        for (int k = 0; k < total; k++) begin
            logic b;
            int   s;
            bit   exp_v;
            b = v.use_lfsr ? lf[0] : v.pat[k % 16];
            if (v.use_lfsr) lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
            bit_in = b;
            s = b ? 1 : -1;
            case (k % 4)
                0:       begin xi[k] = s;  xq[k] = 0;  end
                1:       begin xi[k] = 0;  xq[k] = s;  end
                2:       begin xi[k] = -s; xq[k] = 0;  end
                default: begin xi[k] = 0;  xq[k] = -s; end
            endcase
            @(posedge clk);
            @(negedge clk);
            exp_v = (((k + 1) % rr) == 0) && (((k + 1) / rr) >= 3);
            check(out_valid == exp_v, "R2/R3 strobe", int'(out_valid), int'(exp_v));
            if (exp_v) begin
                int m;
                int ri;
                int rq;
                m  = (k + 1) / rr;
                ri = 0;
                rq = 0;
                for (int d = 1; d < 2 * rr; d++) begin
                    int idx;
                    int w;
                    idx = m * rr - 2 - d;
                    w   = (d <= rr) ? d : 2 * rr - d;
                    if (idx >= 0) begin
                        ri += w * xi[idx];
                        rq += w * xq[idx];
                    end
                end
                check(int'(i_out) == ri, {tag, " I"}, int'(i_out), ri);
                check(int'(q_out) == rq, {tag, " Q"}, int'(q_out), rq);
                if (v.tone) begin
                    check(int'(i_out) == (1 << (2 * ne - 1)), "R6 tone I", int'(i_out), 1 << (2 * ne - 1));
                    check(int'(q_out) == (1 << (2 * ne - 1)), "R6 tone Q", int'(q_out), 1 << (2 * ne - 1));
                end
                last_i = ri;
                last_q = rq;
            end else begin
                check(int'(i_out) == last_i && int'(q_out) == last_q, "R7 hold", int'(i_out), last_i);
            end
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v]);
        end
        // Directed: reset asserted mid-stream clears everything (R1)
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && i_out == '0 && q_out == '0, "R1 mid-run", int'(i_out), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule